// File: doc/BRIEF.md
# Freeze-Stalled Five-Stage Integer Pipeline

This block is a 32-bit in-order integer core split into five stages: fetch, decode with register read, execute, memory access and writeback. It runs a small fixed-length instruction set with three formats: register operations (add, subtract, and, or, signed set-less-than), immediate add and or, word load and store, two compare-and-branch forms and a direct jump. Branch and jump outcomes are settled in the decode stage. The single instruction after any control transfer is always executed.

Nothing in hardware tracks data dependencies, and no result is forwarded. The compiler spaces dependent instructions far enough apart. A too-close consumer sees the older register contents, and that behaviour is defined. The only stall is a global freeze. While the instruction port waits, the data port waits or the write buffer reports busy, every stage register holds its value. The writeback port is brought out so that the surrounding logic can trace retirement.

Top module: `frz_pipe_core`

## Requirements
- R1: An instruction fetched from `imem_addr` at one unfrozen edge appears on the writeback port after four further unfrozen edges. After reset, with no freeze, the first result is visible four cycles after reset is released, and a stream of writing instructions then retires one per cycle.
- R2: Register 0 always reads as zero. An instruction whose destination is register 0 raises no `wb_en` and leaves register 0 at zero.
- R3: Instructions are 32 bits wide. The opcode is in [31:26], rs in [25:21], rt in [20:16], the 16-bit immediate in [15:0] and the jump target in [25:0]. For register operations, rd is in [15:11], shamt in [10:6] and funct in [5:0]. The opcodes are: register operation 0x00, jump 0x02, equal-branch 0x04, not-equal-branch 0x05, add-immediate 0x08, or-immediate 0x0D, load 0x23, store 0x2B. The funct codes are: add 0x20, subtract 0x22, and 0x24, or 0x25, set-less-than 0x2A. A register operation with a nonzero shamt, an unknown funct or an unknown opcode writes nothing.
- R4: Register operations write rd. Set-less-than writes 1 when rs is less than rt as a signed number, and 0 otherwise. The add and or immediate forms write rt, using the 16-bit immediate sign-extended.
- R5: Load and store drive the data port in the memory stage with the address rs plus the sign-extended immediate. A store drives the rt value on `dmem_wdata`. A load writes the word on `dmem_rdata` into rt.
- R6: The equal and not-equal branches compare the rs and rt values with no flags. When taken, the branch target is the address of the delay slot plus the sign-extended offset shifted left by two, and backward offsets are allowed.
- R7: The jump target is bits [31:28] of the delay-slot address, followed by the 26-bit target field, followed by two zero bits.
- R8: The instruction right after a branch or jump always executes. An instruction on the skipped path never writes.
- R9: A register written by one instruction is visible only from the fourth instruction after it onward. The three instructions in between read the older value.
- R10: While `imem_wait`, `dmem_wait` or `wbuf_busy` is high at an edge, the fetch address, every stage register and the writeback port hold. A freeze never commits a register write, never completes a store twice and never drops one.
- R11: Synchronous reset sets the fetch address to `RESET_PC` and empties the pipeline. During reset and in the cycle after it, `wb_en`, `dmem_we` and `dmem_re` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Fetch address (byte address, word aligned) |
| imem_rdata | input | 32 | Instruction word at `imem_addr` |
| imem_wait | input | 1 | Instruction port not ready; freezes the pipeline |
| dmem_addr | output | 32 | Data byte address in the memory stage |
| dmem_wdata | output | 32 | Store data |
| dmem_we | output | 1 | Store request |
| dmem_re | output | 1 | Load request |
| dmem_rdata | input | 32 | Load data for `dmem_addr` |
| dmem_wait | input | 1 | Data port not ready; freezes the pipeline |
| wbuf_busy | input | 1 | Write buffer busy; freezes the pipeline |
| wb_en | output | 1 | Writeback stage holds a register write (it commits at an unfrozen edge) |
| wb_reg | output | 5 | Destination register of that write |
| wb_data | output | 32 | Value of that write |

## Verification
The risky overlap is a freeze that falls in the same cycle as a taken branch or jump resolving in decode. A second risky overlap is a freeze landing while a producer sits in writeback and a close consumer sits in decode. The first must not lose the redirect, and must not run the delay slot twice. The second must not turn a stale read into a fresh one. Pseudo-random freezes, built from the three stall inputs, are laid over a program full of branches, jumps, a backward loop and deliberately close dependencies. Every unfrozen edge is judged against a behavioural instruction model that makes register writes visible only four instructions later. The order and values of the retired writes and stores must match that model exactly.

// File: rtl/frz_pkg.sv
package frz_pkg;
  localparam int INSN_W    = 32;
  localparam int REG_FLD_W = 5;
  localparam int IMM_W     = 16;
  localparam int JT_W      = 26;

  localparam logic [5:0] OPC_REGOP = 6'h00;
  localparam logic [5:0] OPC_JUMP  = 6'h02;
  localparam logic [5:0] OPC_BREQ  = 6'h04;
  localparam logic [5:0] OPC_BRNE  = 6'h05;
  localparam logic [5:0] OPC_ADDI  = 6'h08;
  localparam logic [5:0] OPC_ORI   = 6'h0D;
  localparam logic [5:0] OPC_LOAD  = 6'h23;
  localparam logic [5:0] OPC_STORE = 6'h2B;

  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_SLT = 6'h2A;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_op_e;

  typedef enum logic [1:0] {
    BR_NONE, BR_EQ, BR_NE, BR_JMP
  } br_e;

  typedef struct packed {
    logic                 wen;
    logic [REG_FLD_W-1:0] dst;
    alu_op_e              op;
    logic                 use_imm;
    logic                 ld;
    logic                 st;
  } ctl_t;
endpackage

// File: rtl/frz_decode.sv
module frz_decode
  import frz_pkg::*;
(
  input  logic [INSN_W-1:0]    insn,
  output ctl_t                 ctl,
  output br_e                  br,
  output logic [REG_FLD_W-1:0] rs,
  output logic [REG_FLD_W-1:0] rt,
  output logic [IMM_W-1:0]     imm,
  output logic [JT_W-1:0]      jtgt
);
  logic [5:0]           opc;
  logic [5:0]           fn;
  logic [4:0]           shamt;
  logic [REG_FLD_W-1:0] rd;

  assign opc   = insn[31:26];
  assign rs    = insn[25:21];
  assign rt    = insn[20:16];
  assign rd    = insn[15:11];
  assign shamt = insn[10:6];
  assign fn    = insn[5:0];
  assign imm   = insn[15:0];
  assign jtgt  = insn[25:0];

  always_comb begin
    ctl    = '0;
    ctl.op = ALU_ADD;
    br     = BR_NONE;
    unique case (opc)
      OPC_REGOP: begin
        ctl.dst = rd;
        if (shamt == '0) begin
          unique case (fn)
            FN_ADD:  begin ctl.wen = 1'b1; ctl.op = ALU_ADD; end
            FN_SUB:  begin ctl.wen = 1'b1; ctl.op = ALU_SUB; end
            FN_AND:  begin ctl.wen = 1'b1; ctl.op = ALU_AND; end
            FN_OR:   begin ctl.wen = 1'b1; ctl.op = ALU_OR;  end
            FN_SLT:  begin ctl.wen = 1'b1; ctl.op = ALU_SLT; end
            default: ctl.wen = 1'b0;
          endcase
        end
      end
      OPC_ADDI:  begin ctl.wen = 1'b1; ctl.dst = rt; ctl.use_imm = 1'b1; end
      OPC_ORI:   begin ctl.wen = 1'b1; ctl.dst = rt; ctl.use_imm = 1'b1; ctl.op = ALU_OR; end
      OPC_LOAD:  begin ctl.wen = 1'b1; ctl.dst = rt; ctl.use_imm = 1'b1; ctl.ld = 1'b1; end
      OPC_STORE: begin ctl.use_imm = 1'b1; ctl.st = 1'b1; end
      OPC_BREQ:  br = BR_EQ;
      OPC_BRNE:  br = BR_NE;
      OPC_JUMP:  br = BR_JMP;
      default:   ctl.wen = 1'b0;
    endcase
    if (ctl.dst == '0) ctl.wen = 1'b0;
  end
endmodule

// File: rtl/frz_alu.sv
module frz_alu
  import frz_pkg::*;
#(
  parameter int W = 32
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);
  always_comb begin
    unique case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = '0;
    endcase
  end
endmodule

// File: rtl/frz_regfile.sv
module frz_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b
);
  logic [W-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (we && wa != '0) mem[wa] <= wd;
  end

  assign rd_a = (ra_a == '0) ? '0 : mem[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : mem[ra_b];

  // R2 / R9: a committed write is seen on the next read of that register
  a_r2_write_lands: assert property (@(posedge clk) disable iff (rst)
    (we && wa != '0) |=> ((ra_a != $past(wa)) || (rd_a == $past(wd))));
endmodule

// File: rtl/frz_pipe_core.sv
module frz_pipe_core
  import frz_pkg::*;
#(
  parameter int              XLEN     = 32,
  parameter int              NREG     = 32,
  parameter logic [XLEN-1:0] RESET_PC = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  output logic [XLEN-1:0]      imem_addr,
  input  logic [INSN_W-1:0]    imem_rdata,
  input  logic                 imem_wait,
  output logic [XLEN-1:0]      dmem_addr,
  output logic [XLEN-1:0]      dmem_wdata,
  output logic                 dmem_we,
  output logic                 dmem_re,
  input  logic [XLEN-1:0]      dmem_rdata,
  input  logic                 dmem_wait,
  input  logic                 wbuf_busy,
  output logic                 wb_en,
  output logic [REG_FLD_W-1:0] wb_reg,
  output logic [XLEN-1:0]      wb_data
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic freeze;
  assign freeze = imem_wait | dmem_wait | wbuf_busy;

  // fetch
  logic [XLEN-1:0] pc_q;
  // fetch -> decode
  logic              fd_valid;
  logic [INSN_W-1:0] fd_insn;
  logic [XLEN-1:0]   fd_pc4;
  // decode -> execute
  logic            de_valid;
  ctl_t            de_ctl;
  logic [XLEN-1:0] de_a, de_b, de_imm;
  // execute -> memory
  logic                 em_valid, em_wen, em_ld, em_st;
  logic [REG_FLD_W-1:0] em_dst;
  logic [XLEN-1:0]      em_res, em_sd;
  // memory -> writeback
  logic                 mw_wen;
  logic [REG_FLD_W-1:0] mw_dst;
  logic [XLEN-1:0]      mw_data;

  // decode stage
  ctl_t                 dec_ctl;
  br_e                  dec_br;
  logic [REG_FLD_W-1:0] dec_rs, dec_rt;
  logic [IMM_W-1:0]     dec_imm;
  logic [JT_W-1:0]      dec_jt;
  logic [XLEN-1:0]      rs_val, rt_val, imm_x, br_tgt;
  logic                 take;

  frz_decode u_dec (
    .insn (fd_insn),
    .ctl  (dec_ctl),
    .br   (dec_br),
    .rs   (dec_rs),
    .rt   (dec_rt),
    .imm  (dec_imm),
    .jtgt (dec_jt)
  );

  frz_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk  (clk),
    .rst  (rst),
    .we   (mw_wen & ~freeze),
    .wa   (mw_dst),
    .wd   (mw_data),
    .ra_a (dec_rs),
    .ra_b (dec_rt),
    .rd_a (rs_val),
    .rd_b (rt_val)
  );

  assign imm_x = {{(XLEN-IMM_W){dec_imm[IMM_W-1]}}, dec_imm};

  always_comb begin
    unique case (dec_br)
      BR_EQ:   take = (rs_val == rt_val);
      BR_NE:   take = (rs_val != rt_val);
      BR_JMP:  take = 1'b1;
      default: take = 1'b0;
    endcase
    if (!fd_valid) take = 1'b0;
    if (dec_br == BR_JMP) br_tgt = {fd_pc4[XLEN-1:JT_W+2], dec_jt, 2'b00};
    else                  br_tgt = fd_pc4 + (imm_x << 2);
  end

  // execute stage
  logic [XLEN-1:0] ex_y;
  frz_alu #(.W(XLEN)) u_alu (
    .op (de_ctl.op),
    .a  (de_a),
    .b  (de_ctl.use_imm ? de_imm : de_b),
    .y  (ex_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q     <= RESET_PC;
      fd_valid <= 1'b0;
      fd_insn  <= '0;
      fd_pc4   <= '0;
      de_valid <= 1'b0;
      de_ctl   <= '0;
      de_a     <= '0;
      de_b     <= '0;
      de_imm   <= '0;
      em_valid <= 1'b0;
      em_wen   <= 1'b0;
      em_ld    <= 1'b0;
      em_st    <= 1'b0;
      em_dst   <= '0;
      em_res   <= '0;
      em_sd    <= '0;
      mw_wen   <= 1'b0;
      mw_dst   <= '0;
      mw_data  <= '0;
    end else if (!freeze) begin
      pc_q     <= take ? br_tgt : pc_q + STEP;
      fd_valid <= 1'b1;
      fd_insn  <= imem_rdata;
      fd_pc4   <= pc_q + STEP;
      de_valid <= fd_valid;
      de_ctl   <= fd_valid ? dec_ctl : '0;
      de_a     <= rs_val;
      de_b     <= rt_val;
      de_imm   <= imm_x;
      em_valid <= de_valid;
      em_wen   <= de_valid & de_ctl.wen;
      em_ld    <= de_valid & de_ctl.ld;
      em_st    <= de_valid & de_ctl.st;
      em_dst   <= de_ctl.dst;
      em_res   <= ex_y;
      em_sd    <= de_b;
      mw_wen   <= em_valid & em_wen;
      mw_dst   <= em_dst;
      mw_data  <= em_ld ? dmem_rdata : em_res;
    end
  end

  assign imem_addr  = pc_q;
  assign dmem_addr  = em_res;
  assign dmem_wdata = em_sd;
  assign dmem_we    = em_st;
  assign dmem_re    = em_ld;
  assign wb_en      = mw_wen;
  assign wb_reg     = mw_dst;
  assign wb_data    = mw_data;

  // R10: a freeze holds fetch and writeback state
  a_r10_freeze_pc: assert property (@(posedge clk) disable iff (rst)
    freeze |=> (pc_q == $past(pc_q)));
  a_r10_freeze_wb: assert property (@(posedge clk) disable iff (rst)
    freeze |=> ($stable(wb_en) && $stable(wb_data) && $stable(wb_reg)));
  // R6 / R7: a resolved transfer redirects fetch at the next open edge
  a_r6_redirect: assert property (@(posedge clk) disable iff (rst)
    (take && !freeze) |=> (pc_q == $past(br_tgt)));
  // R1: an occupied execute stage moves on to memory when not frozen
  a_r1_advance: assert property (@(posedge clk) disable iff (rst)
    (de_valid && !freeze) |=> em_valid);
  // R5: one data access at a time
  a_r5_single_access: assert property (@(posedge clk) disable iff (rst)
    !(dmem_we && dmem_re));
  // R11: the pipeline comes out of reset empty
  a_r11_empty_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!wb_en && !dmem_we && !dmem_re));
endmodule

// File: tb/tb_frz_pipe_core.sv
`timescale 1ns/1ps
module tb_frz_pipe_core;
  localparam logic [5:0] K_REG = 6'h00, K_J = 6'h02, K_BEQ = 6'h04, K_BNE = 6'h05;
  localparam logic [5:0] K_ADDI = 6'h08, K_ORI = 6'h0D, K_LW = 6'h23, K_SW = 6'h2B;
  localparam logic [5:0] F_ADD = 6'h20, F_SUB = 6'h22, F_AND = 6'h24, F_OR = 6'h25, F_SLT = 6'h2A;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_wdata, dmem_rdata, wb_data;
  logic imem_wait = 1'b0, dmem_wait = 1'b0, wbuf_busy = 1'b0;
  logic dmem_we, dmem_re, wb_en;
  logic [4:0] wb_reg;

  always #2.5 clk = ~clk;

  logic [31:0] imem [64];
  logic [31:0] dmem [64];
  assign imem_rdata = imem[imem_addr[7:2]];
  assign dmem_rdata = dmem[dmem_addr[7:2]];

  frz_pipe_core dut (
    .clk(clk), .rst(rst),
    .imem_addr(imem_addr), .imem_rdata(imem_rdata), .imem_wait(imem_wait),
    .dmem_addr(dmem_addr), .dmem_wdata(dmem_wdata), .dmem_we(dmem_we), .dmem_re(dmem_re),
    .dmem_rdata(dmem_rdata), .dmem_wait(dmem_wait), .wbuf_busy(wbuf_busy),
    .wb_en(wb_en), .wb_reg(wb_reg), .wb_data(wb_data)
  );

  int nchk = 0;
  int nfail = 0;
  int wp = 0;

  int          exp_reg[$];
  logic [31:0] exp_val[$];
  logic [31:0] exp_pc[$];
  logic [31:0] exp_sa[$];
  logic [31:0] exp_sd[$];

  function automatic logic [31:0] enc_r(logic [5:0] fn, int rs, int rt, int rd);
    return {K_REG, rs[4:0], rt[4:0], rd[4:0], 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
    return {op, rs[4:0], rt[4:0], imm[15:0]};
  endfunction
  function automatic logic [31:0] enc_j(int w);
    return {K_J, w[25:0]};
  endfunction

  task automatic put(logic [31:0] w);
    imem[wp] = w;
    wp++;
  endtask

  function automatic string tag_of(logic [31:0] p);
    int w = int'(p >> 2);
    if (w <= 7) return "R1";
    if (w <= 13) return "R4";
    if (w == 17 || w == 18 || w == 25) return "R5";
    if (w >= 19 && w <= 23) return "R9";
    if (w == 24) return "R2";
    if (w >= 26 && w <= 37) return "R8";
    if (w == 39 || w == 41) return "R7";
    if (w >= 46) return "R6";
    return "R3";
  endfunction

  task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
    end
  endtask

  // behavioural instruction model: delay slot, 4-instruction visibility
  task automatic run_ref();
    logic [31:0] rr [32];
    logic [31:0] rdm [64];
    int          pr[$];
    logic [31:0] pv[$];
    logic [31:0] pc, npc, nn, ins, a, b, sx, res, ea;
    int          dst;
    for (int i = 0; i < 32; i++) rr[i] = '0;
    for (int i = 0; i < 64; i++) rdm[i] = '0;
    pc = 0; npc = 4;
    for (int s = 0; s < 400; s++) begin
      if (pr.size() == 4) begin
        if (pr[0] != 0) rr[pr[0]] = pv[0];
        void'(pr.pop_front());
        void'(pv.pop_front());
      end
      ins = imem[pc[7:2]];
      a   = rr[ins[25:21]];
      b   = rr[ins[20:16]];
      sx  = {{16{ins[15]}}, ins[15:0]};
      ea  = a + sx;
      dst = 0; res = 0; nn = npc + 4;
      case (ins[31:26])
        K_REG: if (ins[10:6] == 0) begin
          case (ins[5:0])
            F_ADD: begin dst = int'(ins[15:11]); res = a + b; end
            F_SUB: begin dst = int'(ins[15:11]); res = a - b; end
            F_AND: begin dst = int'(ins[15:11]); res = a & b; end
            F_OR:  begin dst = int'(ins[15:11]); res = a | b; end
            F_SLT: begin dst = int'(ins[15:11]); res = ($signed(a) < $signed(b)) ? 1 : 0; end
            default: ;
          endcase
        end
        K_ADDI: begin dst = int'(ins[20:16]); res = a + sx; end
        K_ORI:  begin dst = int'(ins[20:16]); res = a | sx; end
        K_LW:   begin dst = int'(ins[20:16]); res = rdm[ea[7:2]]; end
        K_SW:   begin exp_sa.push_back(ea); exp_sd.push_back(b); rdm[ea[7:2]] = b; end
        K_BEQ:  if (a == b) nn = npc + (sx << 2);
        K_BNE:  if (a != b) nn = npc + (sx << 2);
        K_J:    nn = {npc[31:28], ins[25:0], 2'b00};
        default: ;
      endcase
      pr.push_back(dst);
      pv.push_back(res);
      if (dst != 0) begin
        exp_reg.push_back(dst); exp_val.push_back(res); exp_pc.push_back(pc);
      end
      pc = npc; npc = nn;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(5.0 * 20000);
    nchk++; nfail++;
    $display("FAIL watchdog: run did not end (actual hung, expected finish)");
    finish_run();
  end

  initial begin
    logic [31:0] xs, prev_addr, prev_wbd;
    logic prev_st, prev_wbe, st;
    for (int i = 0; i < 64; i++) begin imem[i] = '0; dmem[i] = '0; end
    // program
    put(enc_i(K_ADDI, 0, 1, 5));      // 0
    put(enc_i(K_ADDI, 0, 2, -3));     // 1
    put(enc_i(K_ORI, 0, 3, 'h0F0));   // 2
    put(enc_i(K_ADDI, 0, 4, 64));     // 3
    put(enc_i(K_ADDI, 0, 6, 7));      // 4
    put(enc_i(K_ADDI, 0, 7, -1));     // 5
    put(enc_i(K_ADDI, 0, 8, 1));      // 6
    put(enc_i(K_ADDI, 0, 9, 2));      // 7
    put(enc_r(F_ADD, 1, 2, 5));       // 8
    put(enc_r(F_SUB, 1, 2, 10));      // 9
    put(enc_r(F_AND, 3, 7, 11));      // 10
    put(enc_r(F_OR, 1, 3, 12));       // 11
    put(enc_r(F_SLT, 2, 1, 13));      // 12 signed -3<5
    put(enc_r(F_SLT, 1, 2, 14));      // 13
    put(enc_i(K_SW, 4, 5, 0));        // 14
    put(enc_i(K_SW, 4, 10, 4));       // 15
    put(enc_i(K_ADDI, 0, 0, 9));      // 16 write to r0
    put(enc_i(K_LW, 4, 15, 0));       // 17
    put(enc_i(K_LW, 4, 16, 4));       // 18
    put(enc_i(K_ADDI, 0, 9, 50));     // 19 producer
    put(enc_r(F_ADD, 9, 0, 18));      // 20 stale
    put(enc_r(F_ADD, 9, 0, 19));      // 21 stale
    put(enc_r(F_ADD, 9, 0, 20));      // 22 stale
    put(enc_r(F_ADD, 9, 0, 21));      // 23 fresh
    put(enc_r(F_ADD, 0, 0, 22));      // 24 r0 reads zero
    put(enc_r(F_ADD, 15, 16, 23));    // 25
    put(enc_i(K_BEQ, 1, 1, 2));       // 26 taken
    put(enc_i(K_ADDI, 0, 24, 11));    // 27 delay slot
    put(enc_i(K_ADDI, 0, 25, 99));    // 28 skipped
    put(enc_i(K_BNE, 1, 1, 5));       // 29 not taken
    put(enc_i(K_ADDI, 0, 26, 12));    // 30 delay slot
    put(enc_i(K_ADDI, 0, 27, 13));    // 31
    put(enc_i(K_BNE, 1, 2, 2));       // 32 taken
    put(enc_i(K_ADDI, 0, 28, 14));    // 33 delay slot
    put(enc_i(K_ADDI, 0, 28, 66));    // 34 skipped
    put(enc_i(K_BEQ, 1, 2, 7));       // 35 not taken
    put(enc_i(K_ADDI, 0, 29, 15));    // 36
    put(enc_i(K_ADDI, 0, 30, 16));    // 37
    put(enc_j(41));                   // 38
    put(enc_i(K_ADDI, 0, 31, 17));    // 39 delay slot
    put(enc_i(K_ADDI, 0, 31, 88));    // 40 skipped
    put(enc_r(F_SLT, 7, 0, 24));      // 41
    put(enc_i(K_ADDI, 0, 9, 3));      // 42
    put({K_REG, 5'd1, 5'd1, 5'd9, 5'd1, F_ADD}); // 43 nonzero shamt: no-op
    put(32'h0);                       // 44
    put(32'h0);                       // 45
    put(enc_i(K_ADDI, 9, 9, -1));     // 46 loop head
    put(32'h0);                       // 47
    put(32'h0);                       // 48
    put(32'h0);                       // 49
    put(enc_i(K_BNE, 9, 0, -5));      // 50 backward
    put(enc_i(K_ADDI, 8, 8, 1));      // 51 delay slot
    put(enc_j(52));                   // 52 halt loop
    put(32'h0);                       // 53
    run_ref();

    // R11: reset state
    repeat (3) begin
      @(negedge clk);
      check(imem_addr == 32'h0, "R11", "reset fetch address", imem_addr, 32'h0);
      check(!wb_en && !dmem_we && !dmem_re, "R11", "reset port enables",
            {29'd0, wb_en, dmem_we, dmem_re}, 32'h0);
    end
    rst = 1'b0;
    xs = 32'h1234_5677;
    prev_st = 1'b0; prev_addr = '0; prev_wbe = 1'b0; prev_wbd = '0;
    for (int cyc = 0; cyc < 600; cyc++) begin
      if (cyc >= 16) begin
        xs = xs ^ (xs << 13); xs = xs ^ (xs >> 17); xs = xs ^ (xs << 5);
        imem_wait = (xs[2:0] == 3'd0);
        dmem_wait = (xs[5:3] == 3'd1);
        wbuf_busy = (xs[8:6] == 3'd2);
      end
      st = imem_wait | dmem_wait | wbuf_busy;
      #1;
      if (cyc == 1)
        check(!wb_en && !dmem_we, "R11", "empty after reset", {31'd0, wb_en}, 32'h0);
      if (cyc == 3)
        check(!wb_en, "R1", "no result before four edges", {31'd0, wb_en}, 32'h0);
      if (cyc >= 4 && cyc <= 11)
        check(wb_en, "R1", "one result per cycle", {31'd0, wb_en}, 32'h1);
      if (prev_st) begin
        check(imem_addr == prev_addr, "R10", "fetch address under freeze", imem_addr, prev_addr);
        check(wb_en == prev_wbe && wb_data == prev_wbd, "R10", "writeback under freeze",
              wb_data, prev_wbd);
      end
      if (!st && wb_en) begin
        if (exp_reg.size() == 0) begin
          check(1'b0, "R8", "unexpected write", {27'd0, wb_reg}, 32'h0);
        end else begin
          check(int'(wb_reg) == exp_reg[0] && wb_data == exp_val[0], tag_of(exp_pc[0]),
                $sformatf("write r%0d (insn @%0h)", exp_reg[0], exp_pc[0]),
                {wb_reg, wb_data[26:0]}, {exp_reg[0][4:0], exp_val[0][26:0]});
          if (wb_data != exp_val[0])
            $display("  value detail: actual %h expected %h", wb_data, exp_val[0]);
          void'(exp_reg.pop_front()); void'(exp_val.pop_front()); void'(exp_pc.pop_front());
        end
      end
      if (!st && dmem_we) begin
        if (exp_sa.size() == 0) begin
          check(1'b0, "R5", "unexpected store", dmem_addr, 32'h0);
        end else begin
          check(dmem_addr == exp_sa[0], "R5", "store address", dmem_addr, exp_sa[0]);
          check(dmem_wdata == exp_sd[0], "R5", "store data", dmem_wdata, exp_sd[0]);
          void'(exp_sa.pop_front()); void'(exp_sd.pop_front());
        end
        dmem[dmem_addr[7:2]] = dmem_wdata;
      end
      prev_st = st; prev_addr = imem_addr; prev_wbe = wb_en; prev_wbd = wb_data;
      @(negedge clk);
    end
    check(exp_reg.size() == 0, "R8", "writes still outstanding", exp_reg.size(), 32'h0);
    check(exp_sa.size() == 0, "R5", "stores still outstanding", exp_sa.size(), 32'h0);
    finish_run();
  end
endmodule